// File: doc/BRIEF.md
# Display panel power sequencer

This block brings a small display panel up and takes it down again. It drives the panel's serial command writer from a fixed internal script. An enable request on an inactive panel starts the bring-up script. The script first waits out the panel's power-on settling time, then sends a three-fold bare zero-command preamble with a short gap after each one. After that it issues the ordered register writes and ends with the display-on command, at which point the panel is reported active. A disable request on an active panel runs a short shutdown script and clears the active status.

Each script step is a bare command, a command with one data byte, a command with two data bytes, a timed wait, or an end marker. Writes are handed to the serial writer one at a time through a request/done handshake that carries a word count and up to three 9-bit words. An error returned by any write is collected into a sticky flag and does not stop the script. Wait lengths are counted in system clocks and set by parameters.

Top module: `panel_seq`

## Requirements
- R1: After reset, `active`, `busy`, `err` and `wr_req` are all 0.
- R2: On an accepted enable request, no write is issued for `POWER_WAIT_CLKS` clocks. The first write request rises exactly `POWER_WAIT_CLKS`+2 clocks after `busy` rises.
- R3: Bring-up begins with three bare writes of command 0x00. After each of them there are `GAP_CLKS`+2 clocks with `wr_req` low before the next write. Consecutive writes with no wait between them have one low clock.
- R4: Word format: `wr_cnt` is 1 for a bare command, 2 for one data byte and 3 for two data bytes. Each word is 9 bits. Bit 8 is 0 for a command and 1 for data. Word 0 sits in `wr_words[26:18]`, word 1 in `[17:9]` and word 2 in `[8:0]`. A 16-bit value is sent high byte first. Unused words are zero.
- R5: After the preamble, bring-up sends, in this order: 0xB0←0x17, 0xBC←0x80, 0x3B←0x00, 0xB0←0x16, 0xB8←0xFFF9 (two bytes), bare 0x11.
- R6: The last bring-up write is bare 0x29. On the clock after its completion, `active` becomes 1 and `busy` becomes 0.
- R7: Shutdown sends, in this order: bare 0x28, 0xB8←0x8002 (two bytes), bare 0x10, 0xB0←0x00. After that, `active` becomes 0.
- R8: An enable request while active, or a disable request while inactive and idle, starts nothing: `busy` and `wr_req` stay 0.
- R9: A write that completes with `wr_err` high sets `err`, which stays 1 until reset. The script continues with the remaining writes.
- R10: Enable or disable requests that arrive while a script runs are remembered. They are acted on once the running script ends, so two scripts never interleave.
- R11: `wr_req` stays high, with `wr_cnt` and `wr_words` stable, until `wr_done` is seen. Only one write is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Request to bring the panel up |
| dis_req | input | 1 | Request to take the panel down |
| active | output | 1 | Panel has completed bring-up |
| busy | output | 1 | A script is running |
| err | output | 1 | Sticky write-error flag |
| wr_req | output | 1 | Write request to the serial writer |
| wr_cnt | output | 2 | Number of words in the write (1 to 3) |
| wr_words | output | 27 | Three 9-bit words, word 0 in the top bits |
| wr_done | input | 1 | Serial writer finished the current write |
| wr_err | input | 1 | Serial writer error, valid with `wr_done` |

## Verification
A wrong script pointer or a bad step decode shows up on the first write request that follows, as a wrong command byte, data byte or word count. A miscounted wait shows up as a shifted edge on `wr_req`, one clock off at the earliest point where it can appear. A lost pending request or a wrong end marker shows up within one clock of the script's end, as `busy` dropping or `active` taking the wrong value. The bench compares all of these against its own model on every clock. It also checks the logged command order and the gap lengths after each script.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   localparam int WORD_W    = 9;
   localparam int MAX_WORDS = 3;
   localparam int ROM_DEPTH = 20;
   localparam int PC_W      = $clog2(ROM_DEPTH);
   localparam int UP_BASE   = 0;
   localparam int DOWN_BASE = 15;

   typedef enum logic [2:0] {
      K_BARE = 3'd0,
      K_B1   = 3'd1,
      K_B2   = 3'd2,
      K_DLY  = 3'd3,
      K_END  = 3'd4
   } kind_e;

   // val: data for writes; wait select for K_DLY (0 long, 1 short);
   // resulting active level for K_END
   typedef struct packed {
      kind_e       kind;
      logic [7:0]  cmd;
      logic [15:0] val;
   } step_t;

   function automatic step_t mk(kind_e k, logic [7:0] c, logic [15:0] v);
      step_t s;
      s.kind = k;
      s.cmd  = c;
      s.val  = v;
      return s;
   endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
   import panel_seq_pkg::*;
(
   input  logic [PC_W-1:0] addr,
   output step_t           step
);

   always_comb begin
      case (int'(addr))
         // bring-up script
         0:  step = mk(K_DLY,  8'h00, 16'h0000);
         1:  step = mk(K_BARE, 8'h00, 16'h0000);
         2:  step = mk(K_DLY,  8'h00, 16'h0001);
         3:  step = mk(K_BARE, 8'h00, 16'h0000);
         4:  step = mk(K_DLY,  8'h00, 16'h0001);
         5:  step = mk(K_BARE, 8'h00, 16'h0000);
         6:  step = mk(K_DLY,  8'h00, 16'h0001);
         7:  step = mk(K_B1,   8'hB0, 16'h0017);
         8:  step = mk(K_B1,   8'hBC, 16'h0080);
         9:  step = mk(K_B1,   8'h3B, 16'h0000);
         10: step = mk(K_B1,   8'hB0, 16'h0016);
         11: step = mk(K_B2,   8'hB8, 16'hFFF9);
         12: step = mk(K_BARE, 8'h11, 16'h0000);
         13: step = mk(K_BARE, 8'h29, 16'h0000);
         14: step = mk(K_END,  8'h00, 16'h0001);
         // shutdown script
         15: step = mk(K_BARE, 8'h28, 16'h0000);
         16: step = mk(K_B2,   8'hB8, 16'h8002);
         17: step = mk(K_BARE, 8'h10, 16'h0000);
         18: step = mk(K_B1,   8'hB0, 16'h0000);
         default: step = mk(K_END, 8'h00, 16'h0000);
      endcase
   end

endmodule

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
   parameter int unsigned LONG_CLKS  = 9_000_000,
   parameter int unsigned SHORT_CLKS = 100_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sel_long,
   output logic expired
);

   localparam int unsigned MAX_CLKS = (LONG_CLKS > SHORT_CLKS) ? LONG_CLKS : SHORT_CLKS;
   localparam int          CNT_W    = $clog2(MAX_CLKS + 1);

   if (LONG_CLKS == 0 || SHORT_CLKS == 0) begin : g_bad_len
      $error("panel_seq_timer: wait lengths must be at least one clock");
   end

   if (MAX_CLKS == 1) begin : g_single
      assign expired = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (load)
            cnt <= sel_long ? CNT_W'(LONG_CLKS - 1) : CNT_W'(SHORT_CLKS - 1);
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign expired = (cnt == '0);
   end

endmodule

// File: rtl/panel_seq.sv
module panel_seq
   import panel_seq_pkg::*;
#(
   parameter int unsigned POWER_WAIT_CLKS = 9_000_000,
   parameter int unsigned GAP_CLKS        = 100_000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en_req,
   input  logic                          dis_req,
   output logic                          active,
   output logic                          busy,
   output logic                          err,
   output logic                          wr_req,
   output logic [1:0]                    wr_cnt,
   output logic [WORD_W*MAX_WORDS-1:0]   wr_words,
   input  logic                          wr_done,
   input  logic                          wr_err
);

   typedef enum logic [1:0] {S_IDLE, S_STEP, S_WRITE, S_WAIT} state_e;

   state_e            state;
   logic [PC_W-1:0]   pc;
   step_t             step;
   logic              pend_en;
   logic              pend_dis;
   logic              tmr_load;
   logic              tmr_exp;
   logic [WORD_W-1:0] word [MAX_WORDS];

   panel_seq_rom u_rom (
      .addr (pc),
      .step (step)
   );

   assign tmr_load = (state == S_STEP) && (step.kind == K_DLY);

   panel_seq_timer #(
      .LONG_CLKS  (POWER_WAIT_CLKS),
      .SHORT_CLKS (GAP_CLKS)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .sel_long (!step.val[0]),
      .expired  (tmr_exp)
   );

   assign busy = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pc       <= '0;
         active   <= 1'b0;
         err      <= 1'b0;
         wr_req   <= 1'b0;
         pend_en  <= 1'b0;
         pend_dis <= 1'b0;
      end else if (state == S_IDLE) begin
         pend_en  <= 1'b0;
         pend_dis <= 1'b0;
         if (!active && (en_req || pend_en)) begin
            pc    <= PC_W'(UP_BASE);
            state <= S_STEP;
         end else if (active && (dis_req || pend_dis)) begin
            pc    <= PC_W'(DOWN_BASE);
            state <= S_STEP;
         end
      end else begin
         if (en_req)  pend_en  <= 1'b1;
         if (dis_req) pend_dis <= 1'b1;
         case (state)
            S_STEP: begin
               if (step.kind == K_DLY) begin
                  state <= S_WAIT;
               end else if (step.kind == K_END) begin
                  active <= step.val[0];
                  state  <= S_IDLE;
               end else begin
                  wr_req <= 1'b1;
                  state  <= S_WRITE;
               end
            end
            S_WRITE: begin
               if (wr_done) begin
                  wr_req <= 1'b0;
                  err    <= err | wr_err;
                  pc     <= pc + 1'b1;
                  state  <= S_STEP;
               end
            end
            default: begin
               if (tmr_exp) begin
                  pc    <= pc + 1'b1;
                  state <= S_STEP;
               end
            end
         endcase
      end
   end

   // word assembly: command first, data high byte before low byte
   always_comb begin
      word[0] = {1'b0, step.cmd};
      word[1] = '0;
      word[2] = '0;
      wr_cnt  = 2'd1;
      if (step.kind == K_B1) begin
         word[1] = {1'b1, step.val[7:0]};
         wr_cnt  = 2'd2;
      end else if (step.kind == K_B2) begin
         word[1] = {1'b1, step.val[15:8]};
         word[2] = {1'b1, step.val[7:0]};
         wr_cnt  = 2'd3;
      end
   end

   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_pack
      assign wr_words[(MAX_WORDS-1-g)*WORD_W +: WORD_W] = word[g];
   end

   // R11: request held with stable payload until done
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> wr_req);
   assert_words_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> ($stable(wr_words) && $stable(wr_cnt)));
   // R4: word count always in range while requesting
   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wr_cnt != 2'd0));
   // R8: nothing is written while no script runs
   assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_req);
   // R2, R3: no write during a timed wait
   assert_no_req_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT) |-> !wr_req);
   // R9: error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R6: active changes only at the end of a script
   assert_active_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> ($past(busy) && !busy));

endmodule

// File: tb/sim_panel_seq.sv
module sim_panel_seq;

   localparam int PW = 40;
   localparam int GP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_req = 1'b0, dis_req = 1'b0, wr_done = 1'b0, wr_err = 1'b0;
   logic active, busy, err, wr_req;
   logic [1:0]  wr_cnt;
   logic [26:0] wr_words;

   always #5 clk = ~clk;

   panel_seq #(.POWER_WAIT_CLKS(PW), .GAP_CLKS(GP)) u0 (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .active(active), .busy(busy), .err(err), .wr_req(wr_req),
      .wr_cnt(wr_cnt), .wr_words(wr_words), .wr_done(wr_done), .wr_err(wr_err)
   );

   int tests = 0;
   int fails = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct {
      int          kind;   // 0 bare, 1 one byte, 2 two bytes, 3 wait, 4 end
      logic [7:0]  cmd;
      logic [15:0] val;
      int          len;
   } mstep_t;

   mstep_t mq[$];
   int  m_phase = 0;
   int  m_left = 0;
   bit  m_busy = 0, m_active = 0, m_err = 0, m_req = 0, m_pen = 0, m_pdn = 0;
   bit  m_e, m_d;

   function automatic mstep_t ms(int k, logic [7:0] c, logic [15:0] v, int l);
      mstep_t s;
      s.kind = k; s.cmd = c; s.val = v; s.len = l;
      return s;
   endfunction

   task automatic load_up();
      mq.delete();
      mq.push_back(ms(3, 8'h00, 16'h0, PW));
      for (int i = 0; i < 3; i++) begin
         mq.push_back(ms(0, 8'h00, 16'h0, 0));
         mq.push_back(ms(3, 8'h00, 16'h0, GP));
      end
      mq.push_back(ms(1, 8'hB0, 16'h0017, 0));
      mq.push_back(ms(1, 8'hBC, 16'h0080, 0));
      mq.push_back(ms(1, 8'h3B, 16'h0000, 0));
      mq.push_back(ms(1, 8'hB0, 16'h0016, 0));
      mq.push_back(ms(2, 8'hB8, 16'hFFF9, 0));
      mq.push_back(ms(0, 8'h11, 16'h0, 0));
      mq.push_back(ms(0, 8'h29, 16'h0, 0));
      mq.push_back(ms(4, 8'h00, 16'h1, 0));
   endtask

   task automatic load_down();
      mq.delete();
      mq.push_back(ms(0, 8'h28, 16'h0, 0));
      mq.push_back(ms(2, 8'hB8, 16'h8002, 0));
      mq.push_back(ms(0, 8'h10, 16'h0, 0));
      mq.push_back(ms(1, 8'hB0, 16'h0000, 0));
      mq.push_back(ms(4, 8'h00, 16'h0, 0));
   endtask

   function automatic logic [26:0] exp_words(mstep_t s);
      logic [8:0] w1, w2;
      w1 = '0; w2 = '0;
      if (s.kind == 2) begin
         w1 = {1'b1, s.val[15:8]};
         w2 = {1'b1, s.val[7:0]};
      end else if (s.kind == 1) begin
         w1 = {1'b1, s.val[7:0]};
      end
      return {1'b0, s.cmd, w1, w2};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_busy = 0; m_active = 0; m_err = 0; m_req = 0;
         m_pen = 0; m_pdn = 0; mq.delete();
      end else begin
         if (m_phase == 0) begin
            m_e = en_req || m_pen;
            m_d = dis_req || m_pdn;
            m_pen = 0; m_pdn = 0;
            if (!m_active && m_e) begin load_up(); m_phase = 1; end
            else if (m_active && m_d) begin load_down(); m_phase = 1; end
         end else begin
            if (en_req)  m_pen = 1;
            if (dis_req) m_pdn = 1;
            if (m_phase == 1) begin
               if (mq[0].kind == 3) begin m_left = mq[0].len - 1; m_phase = 3; end
               else if (mq[0].kind == 4) begin m_active = mq[0].val[0]; mq.delete(); m_phase = 0; end
               else begin m_req = 1; m_phase = 2; end
            end else if (m_phase == 2) begin
               if (wr_done) begin
                  m_err = m_err | wr_err; m_req = 0;
                  void'(mq.pop_front()); m_phase = 1;
               end
            end else begin
               if (m_left == 0) begin void'(mq.pop_front()); m_phase = 1; end
               else m_left--;
            end
         end
         m_busy = (m_phase != 0);
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(busy == m_busy, "R10 busy", busy, m_busy);
         check(active == m_active, "R6 active", active, m_active);
         check(err == m_err, "R9 err", err, m_err);
         check(wr_req == m_req, "R11 wr_req", wr_req, m_req);
         if (wr_req && m_phase == 2) begin
            check(wr_words == exp_words(mq[0]), "R4 words", wr_words, exp_words(mq[0]));
            check(int'(wr_cnt) == mq[0].kind + 1, "R4 count", wr_cnt, mq[0].kind + 1);
         end
      end
   end

   // ---------------- serial writer responder ----------------
   int  rc = 0;
   bit  err_arm = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         wr_done = 0; wr_err = 0; rc = 0;
      end else if (wr_req && !wr_done) begin
         if (rc == 2) begin
            wr_done = 1; wr_err = err_arm; err_arm = 0; rc = 0;
         end else rc++;
      end else begin
         wr_done = 0; wr_err = 0; rc = 0;
      end
   end

   // ---------------- write log ----------------
   logic [26:0] obs_w[$];
   int          gaps[$];
   int          low_run = 0;
   bit          prev_req = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_req && !prev_req) begin
            obs_w.push_back(wr_words);
            gaps.push_back(low_run);
            low_run = 0;
         end
         if (!busy) low_run = 0;
         else if (!wr_req) low_run++;
         prev_req = wr_req;
      end
   end

   // ---------------- stimulus ----------------
   task automatic pulse_en();
      @(negedge clk) en_req = 1;
      @(negedge clk) en_req = 0;
   endtask
   task automatic pulse_dis();
      @(negedge clk) dis_req = 1;
      @(negedge clk) dis_req = 0;
   endtask
   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   logic [7:0] up_cmds[10]  = '{8'h00, 8'h00, 8'h00, 8'hB0, 8'hBC, 8'h3B, 8'hB0, 8'hB8, 8'h11, 8'h29};
   logic [7:0] dn_cmds[4]   = '{8'h28, 8'hB8, 8'h10, 8'hB0};

   task automatic check_cmds(int base, bit up, string tag);
      int n;
      n = up ? 10 : 4;
      for (int i = 0; i < n; i++) begin
         logic [7:0] e;
         e = up ? up_cmds[i] : dn_cmds[i];
         check(obs_w[base+i][25:18] == e, tag, obs_w[base+i][25:18], e);
      end
   endtask

   initial begin
      int base;
      int quiet;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check({active, busy, err, wr_req} == 4'b0000, "R1 reset outputs", {active, busy, err, wr_req}, 0);

      // bring-up
      base = obs_w.size();
      pulse_en();
      wait_idle();
      check(obs_w.size() == base + 10, "R5 bring-up write count", obs_w.size() - base, 10);
      check_cmds(base, 1, "R5 bring-up order");
      check(gaps[base] == PW + 2, "R2 power wait", gaps[base], PW + 2);
      for (int i = 1; i < 4; i++)
         check(gaps[base+i] == GP + 2, "R3 preamble gap", gaps[base+i], GP + 2);
      for (int i = 4; i < 10; i++)
         check(gaps[base+i] == 1, "R3 back-to-back gap", gaps[base+i], 1);
      check(obs_w[base+7] == {9'h0B8, 9'h1FF, 9'h1F9}, "R4 two-byte order", obs_w[base+7], {9'h0B8, 9'h1FF, 9'h1F9});
      check(obs_w[base+9][25:18] == 8'h29, "R6 last command", obs_w[base+9][25:18], 8'h29);
      check(active == 1, "R6 active after bring-up", active, 1);

      // R8 enable while active
      base = obs_w.size();
      pulse_en();
      quiet = 0;
      repeat (20) begin
         @(negedge clk);
         if (busy || wr_req) quiet++;
      end
      check(quiet == 0 && obs_w.size() == base, "R8 enable while active", quiet, 0);

      // shutdown
      pulse_dis();
      wait_idle();
      check(obs_w.size() == base + 4, "R7 shutdown write count", obs_w.size() - base, 4);
      check_cmds(base, 0, "R7 shutdown order");
      check(obs_w[base+1] == {9'h0B8, 9'h180, 9'h102}, "R7 two-byte value", obs_w[base+1], {9'h0B8, 9'h180, 9'h102});
      check(active == 0, "R7 inactive after shutdown", active, 0);

      // R8 disable while inactive
      base = obs_w.size();
      pulse_dis();
      quiet = 0;
      repeat (20) begin
         @(negedge clk);
         if (busy || wr_req) quiet++;
      end
      check(quiet == 0 && obs_w.size() == base, "R8 disable while inactive", quiet, 0);

      // R9 error mid-run, R10 requests held during a run
      check(err == 0, "R9 err clear before fault", err, 0);
      err_arm = 1;
      pulse_en();
      repeat (8) @(negedge clk);
      en_req = 1; dis_req = 1;
      @(negedge clk);
      en_req = 0; dis_req = 0;
      wait_idle();
      check(active == 1, "R10 bring-up completes first", active, 1);
      @(negedge clk);
      check(busy == 1, "R10 held disable starts", busy, 1);
      wait_idle();
      check(obs_w.size() == base + 14, "R9 script continues after error", obs_w.size() - base, 14);
      check_cmds(base, 1, "R10 bring-up order kept");
      check_cmds(base + 10, 0, "R10 shutdown follows");
      check(active == 0, "R10 inactive at end", active, 0);
      repeat (10) @(negedge clk);
      check(err == 1, "R9 err sticky", err, 1);
      check(busy == 0, "R10 held enable ignored", busy, 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule